// File: doc/BRIEF.md
# Configurable Four-Table Logic Slice

This block models one programmable logic slice. It holds four 4-input lookup tables and a wide-logic stage behind them. The wide-logic stage can merge the tables into 5-input or 6-input functions, or into 4:1 and 8:1 multiplexers. Each table also feeds a ripple carry chain that starts at a carry input from the neighbouring slice. A configuration word is shifted in one bit per clock through a serial port. That word holds the four truth tables, the combining mode and the style of each register.

Each table drives two flip-flops, so the slice has eight registers. The even register of table k stores the slice output k after the wide stage. The odd register stores the table's own raw output. Each register has three configuration bits: one picks between two clocks, one picks between two clock enables, and one picks whether the shared set and reset requests act at a clock edge or at once. The combinational outputs and the registered outputs are both visible at the ports.

Top module: `lut_slice`

## Requirements
- R1: All eight registers read 0 in each of these cases: `rst_n` is low, `cfg_en` is high, or fewer than 90 bits have been shifted since the last rising edge of `cfg_en`. Set requests and clock enables have no effect in these cases.
- R2: While `cfg_en` is high, each rising `clk0` edge shifts `cfg_bit` in at index 89 and moves the whole word one place toward index 0. After 90 shifts, the first bit sent sits at index 0. Table k entry a is bit 16k+a. The mode field is bits 65:64. The clock select of register r is bit 66+r. Its enable select is bit 74+r. Its async flag is bit 82+r. The word does not change while `cfg_en` is low.
- R3: Mode 0 (four separate tables): table k is addressed by `din[4k+3:4k]` (bit 0 is the least significant address bit), and `comb_o[k]` is that table's output.
- R4: Mode 1 (two 5-input functions): tables 0 and 1 are both addressed by `din[3:0]`, and `comb_o[0]` is table 1 when `sel[0]`=1, otherwise table 0. Tables 2 and 3 are both addressed by `din[11:8]`, and `comb_o[2]` is table 3 when `sel[2]`=1, otherwise table 2. `comb_o[1]` and `comb_o[3]` are the raw outputs of tables 1 and 3.
- R5: Mode 2 (one 6-input function): all four tables are addressed by `din[3:0]`. Pair 0 is table 1 when `sel[0]`=1, otherwise table 0. Pair 1 is table 3 when `sel[0]`=1, otherwise table 2. `comb_o[0]` is pair 1 when `sel[1]`=1, otherwise pair 0. `comb_o[1]` is pair 0, `comb_o[2]` is pair 1 and `comb_o[3]` is table 3.
- R6: Mode 3 (mux tree): each table uses its own address group as in R3. Apart from that, the outputs are formed exactly as in R5, so `comb_o[0]` is an 8:1 selection and `comb_o[1]` and `comb_o[2]` are 4:1 selections.
- R7: The carry chain starts at `cin`. Stage k passes its carry on when the raw output of table k is 1, and otherwise emits `din[4k]`. `cout` is the carry leaving stage 3.
- R8: Register 2k captures `comb_o[k]` and register 2k+1 captures the raw output of table k. Capture happens on a rising edge of the register's selected clock when its selected enable is 1. The new value is visible right after that edge.
- R9: A register whose clock select is 1 updates only on `clk1` edges. While `clk1` is idle it holds its value across `clk0` edges.
- R10: A register whose selected enable (`ce[0]` for select 0, `ce[1]` for select 1) is 0 holds its value across clock edges.
- R11: With the async flag at 0, `rst_req` and `set_req` act only at the selected clock edge, whatever the enable. They clear the register or set it to 1. When both are high, the register clears.
- R12: With the async flag at 1, `rst_req` clears the register and `set_req` sets it with no clock edge. When both are high, the register clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | First slice clock; also clocks the configuration port |
| clk1 | input | 1 | Second slice clock |
| rst_n | input | 1 | Active-low asynchronous reset of configuration and registers |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| din | input | 16 | Four 4-bit table input groups |
| sel | input | 4 | Wide-stage select inputs |
| cin | input | 1 | Carry input from the neighbouring slice |
| ce | input | 2 | Two clock enables |
| rst_req | input | 1 | Shared register reset request |
| set_req | input | 1 | Shared register set request |
| comb_o | output | 4 | Combinational slice outputs |
| cout | output | 1 | Carry output |
| reg_o | output | 8 | Register outputs; bit 2k+j is register j of table k |

## Verification
Combinational results (R3 to R7) have no register on their path. They are sampled one time unit after the inputs change, in the same low half-cycle. Register results (R8 to R11) are due at the first selected clock edge after the stimulus and are sampled one time unit after that edge. For R11 the bench also samples before the edge, to show that nothing moves early. Asynchronous effects (R12) are sampled one time unit after the request changes, with no clock edge in between. A configuration takes effect only after exactly 90 shift edges and the fall of `cfg_en`, so every check follows a complete load.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
    localparam int N_LUT      = 4;
    localparam int LUT_IN     = 4;
    localparam int FF_PER_LUT = 2;
    localparam int LUT_BITS   = 1 << LUT_IN;
    localparam int N_REG      = N_LUT * FF_PER_LUT;
    localparam int DIN_W      = N_LUT * LUT_IN;
    localparam int SEL_W      = N_LUT;
    localparam int MODE_W     = 2;
    localparam int MODE_LSB   = N_LUT * LUT_BITS;
    localparam int CSEL_LSB   = MODE_LSB + MODE_W;
    localparam int CESEL_LSB  = CSEL_LSB + N_REG;
    localparam int ASYNC_LSB  = CESEL_LSB + N_REG;
    localparam int CFG_W      = ASYNC_LSB + N_REG;
    localparam int CNT_W      = $clog2(CFG_W + 1);

    typedef enum logic [MODE_W-1:0] {
        MODE_LUT4 = 2'd0,
        MODE_LUT5 = 2'd1,
        MODE_LUT6 = 2'd2,
        MODE_MUX  = 2'd3
    } wide_mode_e;

    typedef struct packed {
        logic [CFG_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
        logic             en_prev;
    } cfg_state_t;
endpackage

// File: rtl/lut_slice_cfg.sv
module lut_slice_cfg
    import lut_slice_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    output logic [CFG_W-1:0] cfg_vec,
    output logic             hold
);
    cfg_state_t st_d, st_q;

    // Shift toward index 0; count edges since the last rise of cfg_en.
    always_comb begin
        st_d         = st_q;
        st_d.en_prev = cfg_en;
        if (cfg_en) begin
            st_d.bits = {cfg_bit, st_q.bits[CFG_W-1:1]};
            if (!st_q.en_prev)
                st_d.cnt = CNT_W'(1);
            else if (st_q.cnt != CNT_W'(CFG_W))
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_vec = st_q.bits;
    assign hold    = !rst_n || cfg_en || (st_q.cnt != CNT_W'(CFG_W));
endmodule

// File: rtl/lut_slice_logic.sv
module lut_slice_logic
    import lut_slice_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_vec,
    input  logic [DIN_W-1:0] din,
    input  logic [SEL_W-1:0] sel,
    input  logic             cin,
    output logic [N_LUT-1:0] comb,
    output logic [N_LUT-1:0] raw,
    output logic             cout
);
    wide_mode_e       mode;
    logic [N_LUT:0]   carry;
    logic             pair0, pair1, top;

    assign mode     = wide_mode_e'(cfg_vec[MODE_LSB +: MODE_W]);
    assign carry[0] = cin;

    for (genvar k = 0; k < N_LUT; k++) begin : g_tbl
        logic [LUT_IN-1:0]   addr;
        logic [LUT_BITS-1:0] tbl;

        assign tbl = cfg_vec[k*LUT_BITS +: LUT_BITS];

        always_comb begin
            unique case (mode)
                MODE_LUT5: addr = din[(k/2)*2*LUT_IN +: LUT_IN];
                MODE_LUT6: addr = din[0 +: LUT_IN];
                default:   addr = din[k*LUT_IN +: LUT_IN];
            endcase
        end

        assign raw[k]     = tbl[addr];
        assign carry[k+1] = raw[k] ? carry[k] : din[k*LUT_IN];
    end

    assign cout = carry[N_LUT];

    // Wide stage: two pair selects feeding one top select.
    always_comb begin
        pair0 = sel[0] ? raw[1] : raw[0];
        pair1 = ((mode == MODE_LUT5) ? sel[2] : sel[0]) ? raw[3] : raw[2];
        top   = sel[1] ? pair1 : pair0;
        unique case (mode)
            MODE_LUT4: comb = raw;
            MODE_LUT5: comb = {raw[3], pair1, raw[1], pair0};
            default:   comb = {raw[3], pair1, pair0, top};
        endcase
    end
endmodule

// File: rtl/lut_slice_seq.sv
module lut_slice_seq
    import lut_slice_pkg::*;
(
    input  logic                  clk0,
    input  logic                  clk1,
    input  logic                  hold,
    input  logic                  rst_req,
    input  logic                  set_req,
    input  logic [1:0]            ce,
    input  logic [FF_PER_LUT-1:0] d,
    input  logic [FF_PER_LUT-1:0] csel,
    input  logic [FF_PER_LUT-1:0] cesel,
    input  logic [FF_PER_LUT-1:0] amode,
    output logic [FF_PER_LUT-1:0] q
);
    for (genvar j = 0; j < FF_PER_LUT; j++) begin : g_ff
        logic rclk, arst, aset;
        logic q_d, q_q;

        assign rclk = csel[j] ? clk1 : clk0;
        assign arst = hold | (amode[j] & rst_req);
        assign aset = amode[j] & set_req;

        always_comb begin
            q_d = q_q;
            if (!amode[j] && rst_req)      q_d = 1'b0;
            else if (!amode[j] && set_req) q_d = 1'b1;
            else if (ce[cesel[j]])         q_d = d[j];
        end

        always_ff @(posedge rclk or posedge arst or posedge aset) begin
            if (arst)      q_q <= 1'b0;
            else if (aset) q_q <= 1'b1;
            else           q_q <= q_d;
        end

        assign q[j] = q_q;
    end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
    import lut_slice_pkg::*;
(
    input  logic             clk0,
    input  logic             clk1,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic [DIN_W-1:0] din,
    input  logic [SEL_W-1:0] sel,
    input  logic             cin,
    input  logic [1:0]       ce,
    input  logic             rst_req,
    input  logic             set_req,
    output logic [N_LUT-1:0] comb_o,
    output logic             cout,
    output logic [N_REG-1:0] reg_o
);
    logic [CFG_W-1:0] cfg_vec;
    logic             hold;
    logic [N_LUT-1:0] raw;

    lut_slice_cfg u_cfg (
        .clk     (clk0),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .cfg_vec (cfg_vec),
        .hold    (hold)
    );

    lut_slice_logic u_logic (
        .cfg_vec (cfg_vec),
        .din     (din),
        .sel     (sel),
        .cin     (cin),
        .comb    (comb_o),
        .raw     (raw),
        .cout    (cout)
    );

    for (genvar k = 0; k < N_LUT; k++) begin : g_seq
        lut_slice_seq u_seq (
            .clk0    (clk0),
            .clk1    (clk1),
            .hold    (hold),
            .rst_req (rst_req),
            .set_req (set_req),
            .ce      (ce),
            .d       ({raw[k], comb_o[k]}),
            .csel    (cfg_vec[CSEL_LSB  + k*FF_PER_LUT +: FF_PER_LUT]),
            .cesel   (cfg_vec[CESEL_LSB + k*FF_PER_LUT +: FF_PER_LUT]),
            .amode   (cfg_vec[ASYNC_LSB + k*FF_PER_LUT +: FF_PER_LUT]),
            .q       (reg_o[k*FF_PER_LUT +: FF_PER_LUT])
        );
    end
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk
    import lut_slice_pkg::*;
(
    input  logic              clk0,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              hold,
    input  logic [CFG_W-1:0]  cfg_vec,
    input  logic [MODE_W-1:0] mode,
    input  logic              csel0,
    input  logic              cesel0,
    input  logic              async0,
    input  logic              cin,
    input  logic [1:0]        ce,
    input  logic              rst_req,
    input  logic              set_req,
    input  logic [N_LUT-1:0]  comb_o,
    input  logic              cout,
    input  logic [N_REG-1:0]  reg_o
);
    // R1: registers stay clear while configuration is being loaded
    p_hold_clear_r1: assert property (@(posedge clk0) disable iff (!rst_n)
        cfg_en |-> (reg_o == '0));

    // R2: configuration word is frozen outside of loading
    p_cfg_frozen_r2: assert property (@(posedge clk0) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_vec));

    // R7: all tables at 1 in mode 0 pass the carry straight through
    p_carry_pass_r7: assert property (@(posedge clk0) disable iff (!rst_n)
        (mode == 2'd0 && comb_o == '1) |-> (cout == cin));

    // R11: synchronous reset clears register 0 at the next edge
    p_sync_rst_r11: assert property (@(posedge clk0) disable iff (!rst_n || hold)
        (!async0 && !csel0 && rst_req) |=> (reg_o[0] == 1'b0));

    // R11: synchronous set without reset sets register 0
    p_sync_set_r11: assert property (@(posedge clk0) disable iff (!rst_n || hold)
        (!async0 && !csel0 && set_req && !rst_req) |=> (reg_o[0] == 1'b1));

    // R10: disabled register keeps its value
    p_ce_hold_r10: assert property (@(posedge clk0) disable iff (!rst_n || hold)
        (!async0 && !csel0 && !rst_req && !set_req && !ce[cesel0]) |=> $stable(reg_o[0]));

    // R12: asynchronous reset holds register 0 clear without an edge
    p_async_rst_r12: assert property (@(posedge clk0) disable iff (!rst_n || hold)
        (async0 && rst_req) |-> (reg_o[0] == 1'b0));
endmodule

bind lut_slice lut_slice_chk u_chk (
    .clk0    (clk0),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .hold    (hold),
    .cfg_vec (cfg_vec),
    .mode    (cfg_vec[lut_slice_pkg::MODE_LSB +: lut_slice_pkg::MODE_W]),
    .csel0   (cfg_vec[lut_slice_pkg::CSEL_LSB]),
    .cesel0  (cfg_vec[lut_slice_pkg::CESEL_LSB]),
    .async0  (cfg_vec[lut_slice_pkg::ASYNC_LSB]),
    .cin     (cin),
    .ce      (ce),
    .rst_req (rst_req),
    .set_req (set_req),
    .comb_o  (comb_o),
    .cout    (cout),
    .reg_o   (reg_o)
);

// File: tb/tb_lut_slice.sv
module tb_lut_slice;
    import lut_slice_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk0 = 1'b0;
    logic             clk1_en = 1'b1;
    logic             clk1;
    logic             rst_n, cfg_en, cfg_bit, cin, rst_req, set_req;
    logic [DIN_W-1:0] din;
    logic [SEL_W-1:0] sel;
    logic [1:0]       ce;
    logic [N_LUT-1:0] comb_o;
    logic             cout;
    logic [N_REG-1:0] reg_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk0 = ~clk0;
    assign clk1 = clk0 & clk1_en;

    lut_slice dut (
        .clk0(clk0), .clk1(clk1), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .din(din), .sel(sel), .cin(cin), .ce(ce), .rst_req(rst_req), .set_req(set_req),
        .comb_o(comb_o), .cout(cout), .reg_o(reg_o)
    );

    typedef struct {
        string      req;
        int         kind;   // 0 comb_o, 1 reg_o, 2 cout
        logic [7:0] exp;
    } item_t;

    item_t sbq[$];
    event  chk_ev;

    initial begin
        forever begin
            @(chk_ev);
            while (sbq.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0:       act = {4'b0, comb_o};
                    1:       act = reg_o;
                    default: act = {7'b0, cout};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input string req, input int kind, input logic [7:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sbq.push_back(it);
        -> chk_ev;
        wait (sbq.size() == 0);
    endtask

    function automatic logic [CFG_W-1:0] make_cfg(
        input logic [15:0] t0, input logic [15:0] t1, input logic [15:0] t2, input logic [15:0] t3,
        input logic [1:0] md, input logic [7:0] cs, input logic [7:0] es, input logic [7:0] as);
        return {as, es, cs, md, t3, t2, t1, t0};
    endfunction

    // Returns {cout, raw[3:0], comb[3:0]} from the requirement text.
    function automatic logic [8:0] model(input logic [CFG_W-1:0] c, input logic [15:0] d,
                                         input logic [3:0] s, input logic ci);
        logic [1:0]  md;
        logic [3:0]  a [4];
        logic [3:0]  r, o;
        logic        p0, p1, tp, cy;
        md = c[65:64];
        for (int k = 0; k < 4; k++) begin
            if (md == 2'd1)      a[k] = (k < 2) ? d[3:0] : d[11:8];
            else if (md == 2'd2) a[k] = d[3:0];
            else                 a[k] = d[4*k +: 4];
            r[k] = c[16*k + int'(a[k])];
        end
        p0 = s[0] ? r[1] : r[0];
        p1 = ((md == 2'd1) ? s[2] : s[0]) ? r[3] : r[2];
        tp = s[1] ? p1 : p0;
        if (md == 2'd0)      o = r;
        else if (md == 2'd1) o = {r[3], p1, r[1], p0};
        else                 o = {r[3], p1, p0, tp};
        cy = ci;
        for (int k = 0; k < 4; k++) cy = r[k] ? cy : d[4*k];
        return {cy, r, o};
    endfunction

    function automatic logic [7:0] regs_of(input logic [8:0] m);
        logic [7:0] v;
        for (int k = 0; k < 4; k++) begin
            v[2*k]   = m[k];
            v[2*k+1] = m[4+k];
        end
        return v;
    endfunction

    task automatic load(input logic [CFG_W-1:0] v, input int n);
        @(negedge clk0);
        cfg_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            cfg_bit = v[i];
            @(negedge clk0);
        end
        cfg_en = 1'b0;
    endtask

    task automatic comb_case(input string req, input logic [CFG_W-1:0] c,
                             input logic [15:0] d, input logic [3:0] s, input logic ci);
        logic [8:0] m;
        @(negedge clk0);
        din = d; sel = s; cin = ci;
        #1;
        m = model(c, d, s, ci);
        expect_val(req, 0, {4'b0, m[3:0]});
    endtask

    initial begin
        repeat (20000) @(posedge clk0);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [CFG_W-1:0] ca, cb, c2, c3, cr, cas;
        logic [8:0]       m;
        logic [7:0]       prev, nxt;

        rst_n = 0; cfg_en = 0; cfg_bit = 0; din = '0; sel = '0; cin = 0;
        ce = 2'b00; rst_req = 0; set_req = 0;

        ca  = make_cfg(16'h8000, 16'hFFFE, 16'h6996, 16'hA5C3, 2'd0, 8'h00, 8'h00, 8'h00);
        cb  = make_cfg(16'h1E5A, 16'hC38D, 16'h0FF0, 16'h9B27, 2'd1, 8'h00, 8'h00, 8'h00);
        c2  = make_cfg(16'h1E5A, 16'hC38D, 16'h0FF0, 16'h9B27, 2'd2, 8'h00, 8'h00, 8'h00);
        c3  = make_cfg(16'hAAAA, 16'hCCCC, 16'hF0F0, 16'hFF00, 2'd3, 8'h00, 8'h00, 8'h00);
        cr  = make_cfg(16'h1E5A, 16'hC38D, 16'h0FF0, 16'h9B27, 2'd1, 8'hC0, 8'h30, 8'h00);
        cas = make_cfg(16'h8000, 16'hFFFE, 16'h6996, 16'hA5C3, 2'd0, 8'h00, 8'h00, 8'hFF);

        // R1: reset state
        repeat (3) @(negedge clk0);
        #1 expect_val("R1", 1, 8'h00);
        @(negedge clk0); rst_n = 1;

        // R1: incomplete load keeps registers clear despite set request
        load(ca, CFG_W - 1);
        set_req = 1; ce = 2'b11;
        @(posedge clk0); @(posedge clk0); #1;
        expect_val("R1", 1, 8'h00);
        @(negedge clk0); set_req = 0; ce = 2'b00;

        // R2, R3, R7: mode 0
        load(ca, CFG_W);
        comb_case("R2", ca, 16'hFFFF, 4'h0, 1'b0);
        comb_case("R3", ca, 16'h0000, 4'h0, 1'b0);
        comb_case("R3", ca, 16'h1234, 4'h0, 1'b1);
        comb_case("R3", ca, 16'hF0A5, 4'h0, 1'b0);
        comb_case("R3", ca, 16'h8421, 4'h0, 1'b1);
        @(negedge clk0); din = 16'h1234; cin = 1; #1;
        m = model(ca, din, sel, cin); expect_val("R7", 2, {7'b0, m[8]});
        @(negedge clk0); din = 16'h3FFF; cin = 0; #1;
        m = model(ca, din, sel, cin); expect_val("R7", 2, {7'b0, m[8]});
        @(negedge clk0); din = 16'h0F00; cin = 1; #1;
        m = model(ca, din, sel, cin); expect_val("R7", 2, {7'b0, m[8]});

        // R4: mode 1
        load(cb, CFG_W);
        comb_case("R4", cb, 16'h0305, 4'b0000, 1'b0);
        comb_case("R4", cb, 16'h0C07, 4'b0101, 1'b0);
        comb_case("R4", cb, 16'h0A0E, 4'b0100, 1'b0);
        comb_case("R4", cb, 16'h0602, 4'b0001, 1'b0);

        // R5: mode 2
        load(c2, CFG_W);
        for (int s = 0; s < 4; s++) comb_case("R5", c2, 16'h0009, 4'(s), 1'b0);
        comb_case("R5", c2, 16'h000E, 4'b0011, 1'b0);

        // R6: mode 3
        load(c3, CFG_W);
        comb_case("R6", c3, 16'h8421, 4'b0000, 1'b0);
        comb_case("R6", c3, 16'h8421, 4'b0011, 1'b0);
        comb_case("R6", c3, 16'h4812, 4'b0010, 1'b0);
        comb_case("R6", c3, 16'h1248, 4'b0001, 1'b0);

        // R8: capture on clk0/clk1 with both enables on
        load(cr, CFG_W);
        @(negedge clk0); din = 16'h0C07; sel = 4'b0101; ce = 2'b11; clk1_en = 1;
        @(posedge clk0); #1;
        prev = regs_of(model(cr, din, sel, cin));
        expect_val("R8", 1, prev);

        // R10: only enable 0 active, regs 4,5 hold
        @(negedge clk0); din = 16'h0A0E; sel = 4'b0100; ce = 2'b01;
        @(posedge clk0); #1;
        nxt  = regs_of(model(cr, din, sel, cin));
        prev = (nxt & 8'hCF) | (prev & 8'h30);
        expect_val("R10", 1, prev);

        // R10: only enable 1 active, only regs 4,5 update
        @(negedge clk0); din = 16'h0305; sel = 4'b0001; ce = 2'b10;
        @(posedge clk0); #1;
        nxt  = regs_of(model(cr, din, sel, cin));
        prev = (nxt & 8'h30) | (prev & 8'hCF);
        expect_val("R10", 1, prev);

        // R9: clk1 idle, regs 6,7 hold
        @(negedge clk0); clk1_en = 0; din = 16'hFFFF; sel = 4'b0000; ce = 2'b11;
        @(posedge clk0); #1;
        nxt  = regs_of(model(cr, din, sel, cin));
        prev = (nxt & 8'h3F) | (prev & 8'hC0);
        expect_val("R9", 1, prev);
        @(negedge clk0); clk1_en = 1;
        @(posedge clk0); #1;
        expect_val("R9", 1, nxt);

        // R11: synchronous set and reset
        @(negedge clk0); ce = 2'b00; set_req = 1; din = 16'h0000;
        #1 expect_val("R11", 1, nxt);
        @(posedge clk0); #1;
        expect_val("R11", 1, 8'hFF);
        @(negedge clk0); rst_req = 1;
        #1 expect_val("R11", 1, 8'hFF);
        @(posedge clk0); #1;
        expect_val("R11", 1, 8'h00);
        @(negedge clk0); rst_req = 0; set_req = 0;
        @(posedge clk0); #1;
        expect_val("R11", 1, 8'h00);

        // R12: asynchronous set and reset
        load(cas, CFG_W);
        @(negedge clk0); ce = 2'b00; set_req = 1;
        #1 expect_val("R12", 1, 8'hFF);
        @(negedge clk0); rst_req = 1;
        #1 expect_val("R12", 1, 8'h00);
        @(negedge clk0); rst_req = 0; set_req = 0;
        #1 expect_val("R12", 1, 8'h00);
        @(negedge clk0); din = 16'h1234; sel = 4'b0000; ce = 2'b01;
        @(posedge clk0); #1;
        expect_val("R8", 1, regs_of(model(cas, din, sel, cin)));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule